// File: doc/BRIEF.md
# Dual-Channel Fault Response Controller

This block decides how each of two power channels reacts when one of three fault flags rises. The flags are thermal shutdown, high-side switch overcurrent and low-side switch overcurrent. A configuration byte gives each channel and each source its own policy. A source can be set to retry by itself or to latch the channel off. The same byte holds a two-bit code that selects one retry delay, which both channels share.

The block drives one run output per channel. On a latch-off it clears that channel's bit in the enable register, and the channel then waits for firmware to write the bit high again. With auto-retry, an overcurrent fault holds the channel off until the retry timer reaches its limit. A thermal fault with auto-retry holds the channel off until the thermal flag falls, and the timer plays no part. The fault flags are synchronous to the clock. Time is counted from a prescaled tick input, at one tick per 0.1 ms, so the four delay codes map to 36, 72, 144 and 288 ticks.

Top module: `fault_resp_ctrl`

## Requirements
- R1: After reset the configuration byte reads 0x00, both enable bits read 0, both run outputs are 0, both state fields read RUN (0) and both fault-source fields read NONE (0).
- R2: A write with `wr_sel`=0 loads the whole configuration byte, which reads back on `cfg_q`. Bits 7:6 are the delay code. For channel c (0 or 1), bit 3c+2 is the thermal policy, bit 3c+1 the high-side policy and bit 3c the low-side policy, where 1 means latch-off. A write with `wr_sel`=1 loads the enable bits from `wr_data[1:0]`.
- R3: With an overcurrent fault and policy 0, the channel's run output is 0 from the edge that samples the fault. The state field shows RETRY (1). The run output returns high one edge after the timer has counted 36<<code ticks.
- R4: The four delay codes give limits of 36, 72, 144 and 288 ticks, each code doubling the one before it.
- R5: With a thermal fault and policy 0, the state field shows THERMAL (2) and the channel stays off for as long as the flag stays high, however long the retry delay. The edge that samples the flag low returns the channel to RUN.
- R6: With any fault whose policy is 1, the same edge clears that channel's enable bit and moves it to LATCHED (3). The run output stays 0 until firmware writes the enable bit high. After that write the run output rises at the next edge.
- R7: A run output is high only when its channel is in RUN and its enable bit is 1. Faults that arrive while the enable bit is 0 are ignored: state and source stay unchanged.
- R8: A new overcurrent fault during RETRY restarts the full retry delay.
- R9: When a thermal fault and a current-limit fault arrive in the same cycle, the thermal fault decides the response, and the source field reads THERMAL (1).
- R10: When firmware writes an enable bit high in the same cycle as a latching fault on that channel, the fault wins and the bit ends up 0.
- R11: A fault on one channel changes neither the run output, the state nor the enable bit of the other channel.
- R12: The source field holds the last fault that was acted on, coded NONE=0, THERMAL=1, HIGH-SIDE=2 and LOW-SIDE=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Prescaled time tick, one pulse per 0.1 ms |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 configuration byte, 1 enable bits |
| wr_data | input | 8 | Write data |
| th_flt | input | 2 | Thermal fault flag per channel |
| hs_oc | input | 2 | High-side overcurrent flag per channel |
| ls_oc | input | 2 | Low-side overcurrent flag per channel |
| cfg_q | output | 8 | Configuration byte contents |
| en_q | output | 2 | Channel enable bits |
| run | output | 2 | Per-channel run command |
| st_o | output | 4 | Per-channel state, 2 bits each (channel 0 in bits 1:0) |
| src_o | output | 4 | Per-channel last fault source, 2 bits each |

## Verification
The hardest cases to reach from the ports are the ones where two events meet in a single cycle. One is a firmware enable write that lands on the same edge as a latching fault. The other is an overcurrent fault that arrives partway through a retry wait. The directed tasks hold the tick high on every cycle so that the retry count advances exactly one per edge. Each task then places the write strobe and the fault pulse on the same edge, or drives a second fault pulse a fixed number of edges into the wait. It then checks that the run output stays low for the whole restarted delay and rises on the edge that follows.

// File: rtl/fault_resp_pkg.sv
`timescale 1ns/1ps
// Shared types for the fault response controller: channel state and fault
// source codes, and the per-channel policy layout inside the config byte.
package fault_resp_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_RETRY  = 2'd1,
        ST_THERM  = 2'd2,
        ST_LATCH  = 2'd3
    } ch_state_t;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_THERM = 2'd1,
        SRC_HIGH  = 2'd2,
        SRC_LOW   = 2'd3
    } flt_src_t;

    // Policy bits of one channel, MSB first as they sit in the byte.
    typedef struct packed {
        logic th;
        logic hs;
        logic ls;
    } policy_t;

    localparam int POL_W = 3;
    localparam int SEL_W = 2;

endpackage

// File: rtl/fr_cfg_regs.sv
`timescale 1ns/1ps
// Configuration byte and channel enable register.
// Assumes one write port; a clear request from a channel FSM overrides a
// write that sets the same enable bit in the same cycle.
module fr_cfg_regs #(
    parameter int NCH   = 2,
    parameter int CFG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [NCH-1:0]   en_clr,
    output logic [CFG_W-1:0] cfg_q,
    output logic [NCH-1:0]   en_q
);

    // Config byte storage, loaded whole on a config write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en && !wr_sel) begin
            cfg_q <= wr_data;
        end
    end

    // Enable bits: firmware write, then channel clears take precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_en && wr_sel) begin
            en_q <= wr_data[NCH-1:0] & ~en_clr;
        end else begin
            en_q <= en_q & ~en_clr;
        end
    end

endmodule

// File: rtl/fr_retry_timer.sv
`timescale 1ns/1ps
// Per-channel retry timer. Counts ticks while active and saturates at the
// limit BASE << sel. Assumes start and tick are synchronous single-cycle
// qualifiers; start always wins and reloads zero.
module fr_retry_timer #(
    parameter int BASE  = 36,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             active,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             expired
);

    localparam int MAXC = BASE << ((1 << SEL_W) - 1);
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    // Limit doubles with each step of the select code.
    always_comb begin
        limit = CW'(BASE) << sel;
    end

    // Tick counter, reloaded on start, holding once the limit is reached.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= '0;
        end else if (active && tick && (cnt < limit)) begin
            cnt <= cnt + CW'(1);
        end
    end

    // Expiry also covers a select code lowered during a wait.
    always_comb begin
        expired = active && (cnt >= limit);
    end

endmodule

// File: rtl/fr_chan_fsm.sv
`timescale 1ns/1ps
// Fault response state machine for one channel.
// Faults are acted on only while the channel's enable bit is set and the
// channel is in RUN or RETRY. Thermal outranks high-side, which outranks
// low-side. A latching response requests an enable clear for one cycle.
module fr_chan_fsm
    import fault_resp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       th,
    input  logic       hs,
    input  logic       ls,
    input  policy_t    pol,
    input  logic       tmr_exp,
    output logic       tmr_start,
    output logic       tmr_active,
    output logic       en_clr,
    output logic       run,
    output ch_state_t  st,
    output flt_src_t   src
);

    ch_state_t st_n;
    flt_src_t  src_n;
    flt_src_t  pick;
    logic      pick_latch;
    logic      react;

    // Choose the ranking fault and its policy bit.
    always_comb begin
        if (th) begin
            pick       = SRC_THERM;
            pick_latch = pol.th;
        end else if (hs) begin
            pick       = SRC_HIGH;
            pick_latch = pol.hs;
        end else if (ls) begin
            pick       = SRC_LOW;
            pick_latch = pol.ls;
        end else begin
            pick       = SRC_NONE;
            pick_latch = 1'b0;
        end
    end

    // Next-state and side-effect decode.
    always_comb begin
        react     = en && (pick != SRC_NONE) && ((st == ST_RUN) || (st == ST_RETRY));
        st_n      = st;
        src_n     = src;
        tmr_start = 1'b0;
        en_clr    = 1'b0;
        if (react) begin
            src_n = pick;
            if (pick_latch) begin
                st_n   = ST_LATCH;
                en_clr = 1'b1;
            end else if (pick == SRC_THERM) begin
                st_n = ST_THERM;
            end else begin
                st_n      = ST_RETRY;
                tmr_start = 1'b1;
            end
        end else begin
            case (st)
                ST_RETRY: if (tmr_exp) st_n = ST_RUN;
                ST_THERM: if (!th)     st_n = ST_RUN;
                ST_LATCH: if (en)      st_n = ST_RUN;
                default:               st_n = st;
            endcase
        end
    end

    // State and last-source registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_RUN;
            src <= SRC_NONE;
        end else begin
            st  <= st_n;
            src <= src_n;
        end
    end

    // Channel command and timer qualifier derived from registered state.
    always_comb begin
        run        = (st == ST_RUN) && en;
        tmr_active = (st == ST_RETRY);
    end

endmodule

// File: rtl/fault_resp_ctrl.sv
`timescale 1ns/1ps
// Dual-channel fault response controller top. Holds the config byte and
// enable bits, and instantiates one FSM and one retry timer per channel.
// Assumes fault flags and tick are already synchronous to clk.
module fault_resp_ctrl
    import fault_resp_pkg::*;
#(
    parameter int NCH  = 2,
    parameter int BASE = 36
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  wr_en,
    input  logic                  wr_sel,
    input  logic [POL_W*NCH+SEL_W-1:0] wr_data,
    input  logic [NCH-1:0]        th_flt,
    input  logic [NCH-1:0]        hs_oc,
    input  logic [NCH-1:0]        ls_oc,
    output logic [POL_W*NCH+SEL_W-1:0] cfg_q,
    output logic [NCH-1:0]        en_q,
    output logic [NCH-1:0]        run,
    output logic [2*NCH-1:0]      st_o,
    output logic [2*NCH-1:0]      src_o
);

    localparam int CFG_W = POL_W * NCH + SEL_W;

    logic [NCH-1:0]   en_clr;
    logic [NCH-1:0]   tmr_start;
    logic [NCH-1:0]   tmr_active;
    logic [NCH-1:0]   tmr_exp;
    logic [SEL_W-1:0] dly_sel;

    // Delay code sits above all channel policy fields.
    always_comb begin
        dly_sel = cfg_q[CFG_W-1 -: SEL_W];
    end

    fr_cfg_regs #(.NCH(NCH), .CFG_W(CFG_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .en_clr  (en_clr),
        .cfg_q   (cfg_q),
        .en_q    (en_q)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        policy_t   pol;
        ch_state_t st;
        flt_src_t  src;

        // Slice this channel's policy field out of the config byte.
        always_comb begin
            pol = policy_t'(cfg_q[POL_W*c +: POL_W]);
        end

        fr_retry_timer #(.BASE(BASE), .SEL_W(SEL_W)) i_tmr (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (tmr_start[c]),
            .active  (tmr_active[c]),
            .tick    (tick),
            .sel     (dly_sel),
            .expired (tmr_exp[c])
        );

        fr_chan_fsm i_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .en         (en_q[c]),
            .th         (th_flt[c]),
            .hs         (hs_oc[c]),
            .ls         (ls_oc[c]),
            .pol        (pol),
            .tmr_exp    (tmr_exp[c]),
            .tmr_start  (tmr_start[c]),
            .tmr_active (tmr_active[c]),
            .en_clr     (en_clr[c]),
            .run        (run[c]),
            .st         (st),
            .src        (src)
        );

        // Pack status fields, channel 0 in the low bits.
        always_comb begin
            st_o[2*c +: 2]  = st;
            src_o[2*c +: 2] = src;
        end
    end

endmodule

// File: rtl/fault_resp_chk.sv
`timescale 1ns/1ps
// Property checker for fault_resp_ctrl, bound to every instance.
// Observes ports and the per-channel timer expiry only.
module fault_resp_chk #(
    parameter int NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   th_flt,
    input logic [NCH-1:0]   hs_oc,
    input logic [NCH-1:0]   ls_oc,
    input logic [NCH-1:0]   en_q,
    input logic [NCH-1:0]   run,
    input logic [2*NCH-1:0] st_o,
    input logic [2*NCH-1:0] src_o,
    input logic [NCH-1:0]   tmr_exp
);

    logic pv;

    // Marks that at least one edge has passed since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pv <= 1'b0;
        else        pv <= 1'b1;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        a_r6_latch_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
            (pv && st_o[2*c +: 2] == 2'd3 && $past(st_o[2*c +: 2]) != 2'd3) |-> !en_q[c]);

        a_r3_retry_exit_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
            (pv && $past(st_o[2*c +: 2]) == 2'd1 && st_o[2*c +: 2] == 2'd0) |-> $past(tmr_exp[c]));

        a_r5_thermal_exit_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (pv && $past(st_o[2*c +: 2]) == 2'd2 && st_o[2*c +: 2] == 2'd0) |-> !$past(th_flt[c]));

        a_r3_fault_stops_run: assert property (@(posedge clk) disable iff (!rst_n)
            (pv && $past(run[c] && (th_flt[c] || hs_oc[c] || ls_oc[c]))) |-> !run[c]);

        a_r9_thermal_ranks_first: assert property (@(posedge clk) disable iff (!rst_n)
            (pv && $past(run[c] && th_flt[c])) |-> src_o[2*c +: 2] == 2'd1);
    end

endmodule

bind fault_resp_ctrl fault_resp_chk #(.NCH(NCH)) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .th_flt  (th_flt),
    .hs_oc   (hs_oc),
    .ls_oc   (ls_oc),
    .en_q    (en_q),
    .run     (run),
    .st_o    (st_o),
    .src_o   (src_o),
    .tmr_exp (tmr_exp)
);

// File: tb/test_fault_resp_ctrl.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, tick held high so one tick per edge.
module test_fault_resp_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b1;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] th_flt = '0;
    logic [1:0] hs_oc = '0;
    logic [1:0] ls_oc = '0;
    logic [7:0] cfg_q;
    logic [1:0] en_q;
    logic [1:0] run;
    logic [3:0] st_o;
    logic [3:0] src_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fault_resp_ctrl i_fault_resp_ctrl (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .th_flt(th_flt), .hs_oc(hs_oc), .ls_oc(ls_oc),
        .cfg_q(cfg_q), .en_q(en_q), .run(run), .st_o(st_o), .src_o(src_o)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input int act, input int exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        step();
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; th_flt = '0; hs_oc = '0; ls_oc = '0; wr_en = 1'b0;
        step(3);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_reset();
        check(cfg_q, 0, "R1 cfg");
        check(en_q, 0, "R1 en");
        check(run, 0, "R1 run");
        check(st_o, 0, "R1 state");
        check(src_o, 0, "R1 src");
    endtask

    // R7: faults with enable low are ignored, then enabling runs.
    task automatic t_disabled();
        reg_write(1'b1, 8'h02);
        check(run, 2'b10, "R7 only ch1 runs");
        th_flt[0] = 1'b1; hs_oc[0] = 1'b1;
        step();
        th_flt[0] = 1'b0; hs_oc[0] = 1'b0;
        check(st_o[1:0], 0, "R7 ignored state");
        check(src_o[1:0], 0, "R7 ignored src");
        reg_write(1'b1, 8'h03);
        check(run, 2'b11, "R7 both run");
    endtask

    task automatic t_cfg();
        reg_write(1'b0, 8'hA5);
        check(cfg_q, 8'hA5, "R2 cfg readback");
        reg_write(1'b0, 8'h00);
        check(cfg_q, 0, "R2 cfg cleared");
    endtask

    // R3/R4/R11/R12: overcurrent auto-retry with a given code.
    task automatic t_oc_retry(input logic [1:0] code, input bit low_side);
        int lim;
        lim = 36 << code;
        reg_write(1'b0, {code, 6'b0});
        if (low_side) ls_oc[0] = 1'b1; else hs_oc[0] = 1'b1;
        step();
        ls_oc[0] = 1'b0; hs_oc[0] = 1'b0;
        check(run[0], 0, "R3 run off");
        check(st_o[1:0], 1, "R3 retry state");
        check(src_o[1:0], low_side ? 3 : 2, "R12 source code");
        check(run[1], 1, "R11 other channel runs");
        step(lim);
        check(run[0], 0, "R4 still off at limit");
        step();
        check(run[0], 1, "R4 back on after limit");
        check(st_o[3:2], 0, "R11 other state");
    endtask

    task automatic t_restart();
        reg_write(1'b0, 8'h00);
        hs_oc[1] = 1'b1; step(); hs_oc[1] = 1'b0;
        step(20);
        ls_oc[1] = 1'b1; step(); ls_oc[1] = 1'b0;
        step(36);
        check(run[1], 0, "R8 delay restarted");
        check(src_o[3:2], 3, "R8 src updated");
        step();
        check(run[1], 1, "R8 resumes");
    endtask

    task automatic t_thermal();
        reg_write(1'b0, 8'h00);
        th_flt[0] = 1'b1; hs_oc[0] = 1'b1;
        step();
        hs_oc[0] = 1'b0;
        check(st_o[1:0], 2, "R5 thermal state");
        check(src_o[1:0], 1, "R9 thermal ranks first");
        step(100);
        check(run[0], 0, "R5 held off past delay");
        th_flt[0] = 1'b0;
        step();
        check(run[0], 1, "R5 restart on clear");
    endtask

    task automatic t_latch();
        reg_write(1'b0, 8'h02);
        hs_oc[0] = 1'b1; step(); hs_oc[0] = 1'b0;
        check(en_q, 2'b10, "R6 enable cleared");
        check(st_o[1:0], 3, "R6 latched state");
        step(400);
        check(run[0], 0, "R6 stays off");
        reg_write(1'b1, 8'h03);
        check(run[0], 0, "R6 off on write edge");
        step();
        check(run[0], 1, "R6 runs after write");
    endtask

    task automatic t_race();
        reg_write(1'b0, 8'h20);
        th_flt[1] = 1'b1; wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'h03;
        step();
        th_flt[1] = 1'b0; wr_en = 1'b0;
        check(en_q, 2'b01, "R10 fault beats write");
        check(st_o[3:2], 3, "R10 latched");
        check(run[0], 1, "R11 ch0 unaffected");
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        t_reset();
        t_disabled();
        t_cfg();
        t_oc_retry(2'd0, 1'b0);
        t_oc_retry(2'd1, 1'b1);
        t_oc_retry(2'd3, 1'b0);
        t_restart();
        t_thermal();
        t_latch();
        t_race();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule